// File: doc/BRIEF.md
# UART Baud Generator with Prescaler Select

This block turns a fixed 7.3728 MHz reference clock into the timing pulses a UART transmitter and receiver need. Software loads a 16-bit divisor as two bytes. The block emits a one-cycle 16x oversampling tick and a 1x bit-rate strobe. The reference is the block's own clock. Prescaling and division are done with clock enables, so no derived clock is created.

Bit 15 of the divisor never takes part in the count. If the per-port high-speed enable input is low, bit 15 is ignored and the reference is divided by 4 ahead of the divide counter. If the enable is high and bit 15 is set, the divide-by-4 stage is bypassed. The low 15 bits then divide the prescaled rate, so the 16x tick repeats every P*N reference cycles. P is the prescale (4 or 1) and N is the 15-bit count.

Any divisor write, or any change of the high-speed enable, restarts the timing chain. A zero count silences both outputs.

Top module: `baud_gen_top`

## Requirements
- R1: An active-high synchronous reset clears both divisor bytes, the high-speed state and all counters. After reset, both outputs are low and stay low until a divisor is written.
- R2: A pulse on `wr_lo_i` loads `wr_data_i` into divisor bits 7:0, and a pulse on `wr_hi_i` loads it into bits 15:8. The other byte keeps its value.
- R3: Only divisor bits 14:0 (N) take part in the count, so the largest usable N is 32767. With high-speed enable on and divisor 0xFFFF, `tick16_o` repeats every 32767 cycles.
- R4: When divisor bit 15 is 0, the reference is divided by 4, and `tick16_o` repeats every 4*N cycles. N = 1 gives a 16x tick every 4 cycles (115200 bps).
- R5: When bit 15 is 1 and `hs_en_i` is 1, no prescaling is applied, and `tick16_o` repeats every N cycles. Divisors 0x8001, 0x8002, 0x8003 and 0x8004 give periods of 1, 2, 3 and 4 cycles (460800, 230400, 153600 and 115200 bps).
- R6: When `hs_en_i` is 0, bit 15 has no effect: 0x8001 gives the same 4-cycle tick period as 0x0001.
- R7: `tick16_o` is a single-cycle pulse, which becomes continuous only at a period of 1. `tick1_o` is high together with every 16th `tick16_o` counted from the last restart, and never at any other time.
- R8: A write to either divisor byte, or a change of `hs_en_i`, restarts the chain. The first `tick16_o` is then seen exactly P*N cycles after the clock edge that accepted the change, with no earlier tick.
- R9: While N is 0, both `tick16_o` and `tick1_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 7.3728 MHz reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_lo_i | input | 1 | Load strobe for the divisor low byte |
| wr_hi_i | input | 1 | Load strobe for the divisor high byte |
| wr_data_i | input | 8 | Byte to load |
| hs_en_i | input | 1 | Per-port high-speed enable |
| tick16_o | output | 1 | 16x oversampling tick, one cycle wide |
| tick1_o | output | 1 | 1x bit-rate strobe |

## Verification
The hardest case to reach is a restart in the middle of a period. Setting up a divisor is not enough: the counters must already be partly advanced when the restart comes. The stimulus therefore lets a 20-cycle period run for seven cycles and then rewrites the same low byte. It also flips the high-speed enable with no divisor write at all, and checks that the first tick lands a full new period after that edge. The 32767-cycle period is driven to its end so the top count value is used.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic {
        PRE_SLOW = 1'b0,
        PRE_FAST = 1'b1
    } pre_sel_e;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
    parameter int DIV_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_lo_i,
    input  logic               wr_hi_i,
    input  logic [DIV_W/2-1:0] wr_data_i,
    input  logic               hs_en_i,
    output logic [DIV_W-1:0]   div_o,
    output logic               hs_o,
    output logic               reload_o
);
    localparam int BYTE_W = DIV_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              hs;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo_i) st_d.lo = wr_data_i;
        if (wr_hi_i) st_d.hi = wr_data_i;
        st_d.hs = hs_en_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign div_o    = {st_q.hi, st_q.lo};
    assign hs_o     = st_q.hs;
    assign reload_o = wr_lo_i | wr_hi_i | (hs_en_i != st_q.hs);

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_lo_i && !wr_hi_i) |=> $stable(div_o)); // R2
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
#(
    parameter int SLOW_RATIO = 4
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     reload_i,
    input  pre_sel_e sel_i,
    output logic     en_o
);
    localparam int PRE_W = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
    localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(SLOW_RATIO - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last = (sel_i == PRE_FAST) ? '0 : SLOW_LAST;
        en_o = (pre_q == last);
        if (reload_i)          pre_d = '0;
        else if (pre_q >= last) pre_d = '0;
        else                    pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pre_q <= '0;
        else       pre_q <= pre_d;
    end

    AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(pre_q) < SLOW_RATIO); // R4
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int CNT_W = 15,
    parameter int OVS   = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             reload_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] n_i,
    output logic             tick16_o,
    output logic             tick1_o
);
    localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic             t16;
        logic             t1;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.t16 = 1'b0;
        st_d.t1  = 1'b0;
        if (reload_i || (n_i == '0)) begin
            st_d.cnt = '0;
            st_d.sub = '0;
        end else if (en_i) begin
            if (st_q.cnt == n_i - CNT_W'(1)) begin
                st_d.cnt = '0;
                st_d.t16 = 1'b1;
                st_d.t1  = (st_q.sub == SUB_LAST);
                st_d.sub = (st_q.sub == SUB_LAST) ? '0 : st_q.sub + SUB_W'(1);
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign tick16_o = st_q.t16;
    assign tick1_o  = st_q.t1;

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        (n_i != '0) |-> (st_q.cnt < n_i)); // R3
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
    import baud_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int SLOW_RATIO = 4,
    parameter int OVS        = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_lo_i,
    input  logic               wr_hi_i,
    input  logic [DIV_W/2-1:0] wr_data_i,
    input  logic               hs_en_i,
    output logic               tick16_o,
    output logic               tick1_o
);
    localparam int CNT_W = DIV_W - 1;

    logic [DIV_W-1:0] div;
    logic             hs;
    logic             reload;
    logic             pre_en;
    pre_sel_e         sel;
    logic [CNT_W-1:0] n;

    baud_div_latch #(.DIV_W(DIV_W)) latch_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_lo_i  (wr_lo_i),
        .wr_hi_i  (wr_hi_i),
        .wr_data_i(wr_data_i),
        .hs_en_i  (hs_en_i),
        .div_o    (div),
        .hs_o     (hs),
        .reload_o (reload)
    );

    assign sel = (div[DIV_W-1] && hs) ? PRE_FAST : PRE_SLOW;
    assign n   = div[CNT_W-1:0];

    baud_prescale #(.SLOW_RATIO(SLOW_RATIO)) pre_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .reload_i(reload),
        .sel_i   (sel),
        .en_o    (pre_en)
    );

    baud_divider #(.CNT_W(CNT_W), .OVS(OVS)) divr_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .reload_i(reload),
        .en_i    (pre_en),
        .n_i     (n),
        .tick16_o(tick16_o),
        .tick1_o (tick1_o)
    );

    AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (n == '0) |=> !tick16_o); // R9
    AST_STROBE_SUBSET: assert property (@(posedge clk_i) disable iff (rst_i)
        tick1_o |-> tick16_o); // R7
    AST_RELOAD_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        reload |=> !tick16_o); // R8
    AST_SLOW_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel == PRE_SLOW && tick16_o) |=> !tick16_o); // R4
endmodule

// File: tb/baud_gen_top_tb_top.sv
module baud_gen_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       hs_en = 1'b0;
    logic       tick16;
    logic       tick1;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_gen_top dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .wr_lo_i  (wr_lo),
        .wr_hi_i  (wr_hi),
        .wr_data_i(wr_data),
        .hs_en_i  (hs_en),
        .tick16_o (tick16),
        .tick1_o  (tick1)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one byte; returns at the negedge after the accepting edge.
    task automatic wr_byte(input bit hi, input logic [7:0] v);
        @(negedge clk);
        wr_data = v;
        wr_lo = !hi;
        wr_hi = hi;
        @(posedge clk);
        @(negedge clk);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] v);
        wr_byte(1'b1, v[15:8]);
        wr_byte(1'b0, v[7:0]);
    endtask

    task automatic measure(input int exp_first, input int exp_period, input string tag);
        int first = -1;
        int gap = -1;
        for (int i = 1; i <= exp_first + 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (tick16) begin first = i; break; end
        end
        chk(first == exp_first, {tag, " first tick"}, first, exp_first);
        for (int i = 1; i <= exp_period + 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (tick16) begin gap = i; break; end
        end
        chk(gap == exp_period, {tag, " period"}, gap, exp_period);
    endtask

    task automatic quiet(input int cycles, input string tag);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); @(negedge clk);
            if (tick16 || tick1) hits++;
        end
        chk(hits == 0, tag, hits, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!tick16 && !tick1, "R1 outputs low after reset", int'({tick16, tick1}), 0);
        quiet(50, "R1 R9 no ticks with cleared divisor");
    endtask

    task automatic t_slow;
        hs_en = 1'b0;
        set_div(16'h0001);
        measure(4, 4, "R4 div 1 slow");
        set_div(16'h0005);
        measure(20, 20, "R4 div 5 slow");
    endtask

    task automatic t_fast;
        hs_en = 1'b1;
        set_div(16'h8001);
        measure(1, 1, "R5 0x8001");
        wr_byte(1'b0, 8'h03);
        measure(3, 3, "R2 low byte only gives 0x8003");
        set_div(16'h8002);
        measure(2, 2, "R5 0x8002");
        set_div(16'h8004);
        measure(4, 4, "R5 0x8004");
    endtask

    task automatic t_ignore;
        hs_en = 1'b0;
        set_div(16'h8001);
        measure(4, 4, "R6 bit15 ignored");
    endtask

    task automatic t_max;
        hs_en = 1'b1;
        set_div(16'hFFFF);
        measure(32767, 32767, "R3 max count");
    endtask

    task automatic t_zero;
        hs_en = 1'b1;
        set_div(16'h8000);
        quiet(100, "R9 zero count silent");
    endtask

    task automatic t_strobe;
        int n16 = 0;
        int n1 = 0;
        int first1 = -1;
        int bad = 0;
        hs_en = 1'b1;
        set_div(16'h8001);
        for (int i = 1; i <= 40; i++) begin
            @(posedge clk); @(negedge clk);
            if (tick16) n16++;
            if (tick1) begin
                n1++;
                if (first1 < 0) first1 = i;
                if (!tick16 || (n16 % 16) != 0) bad++;
            end
        end
        chk(bad == 0, "R7 strobe on every 16th tick only", bad, 0);
        chk(n1 == 2, "R7 strobe count in 40 cycles", n1, 2);
        chk(first1 == 16, "R7 first strobe", first1, 16);
    endtask

    task automatic t_reload;
        hs_en = 1'b0;
        set_div(16'h0005);
        repeat (7) @(negedge clk);
        wr_byte(1'b0, 8'h05);
        measure(20, 20, "R8 rewrite mid period");
        set_div(16'h8002);
        measure(8, 8, "R8 slow before enable change");
        repeat (3) @(negedge clk);
        hs_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        measure(2, 2, "R8 enable change restarts");
    endtask

    task automatic t_reset_mid;
        hs_en = 1'b1;
        set_div(16'h8001);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        quiet(10, "R1 silent after mid-run reset");
        wr_byte(1'b0, 8'h01);
        measure(4, 4, "R1 high byte cleared by reset");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_slow();
        t_fast();
        t_ignore();
        t_zero();
        t_strobe();
        t_reload();
        t_reset_mid();
        t_max();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule